// File: doc/BRIEF.md
# Predicate Flag File with Dual-Destination Compare

This block keeps a bank of single-bit predicate flags used to qualify instructions. A compare request carries a test selector, two integer operands and two flag indices. The block evaluates the test and, at the next clock edge, writes the outcome to the first index and its inverse to the second. Software can therefore build both arms of a condition with one operation.

On the retirement side, each of several slots names one flag as its guard. The block returns that flag's value and a commit enable for the slot. Guarded instructions always execute. When the guard is false, their result is dropped at retirement through a low commit enable. Flag 0 is hard-wired true, so an unguarded instruction names flag 0.

A flag written by a compare during cycle t is not seen by guard reads in cycle t. It becomes visible from cycle t+1, which is the stage after execute.

Top module: `pred_regfile_top`

## Requirements
- R1: After reset, flag 0 reads 1 and flags 1 to 63 read 0.
- R2: Flag 0 always reads 1. A compare that targets index 0 with either destination leaves it at 1.
- R3: A valid compare writes its test outcome to the index on `cmp_dst_t` and the inverse outcome to the index on `cmp_dst_f`. A guard read sees the new values in the cycle after the request and the old values in the request cycle.
- R4: Opcode values 2, 3, 4 and 5 select signed less-than, less-or-equal, greater-than and greater-or-equal on the 64-bit operands, with `cmp_a` on the left.
- R5: Opcode values 6, 7, 8 and 9 select the same four orderings, treating the operands as unsigned.
- R6: Opcode 0 tests equality and opcode 1 tests inequality.
- R7: When both destination indices are equal and nonzero, that flag receives the inverse outcome.
- R8: Opcode values 10 to 15 write no flag. A request with `cmp_valid` low also writes no flag.
- R9: For each retirement slot s, `guard_val[s]` equals the flag named by `ret_pidx[6*s +: 6]`, and `commit_en[s]` equals `ret_valid[s]` AND that flag.
- R10: A flag holds its value in every cycle in which no valid compare targets it.
- R11: All retirement slots read independently in the same cycle. This includes several slots naming the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare request present this cycle |
| cmp_op | input | 4 | Test selector, 0 to 9 valid |
| cmp_a | input | 64 | Left operand |
| cmp_b | input | 64 | Right operand |
| cmp_dst_t | input | 6 | Flag index that receives the outcome |
| cmp_dst_f | input | 6 | Flag index that receives the inverse outcome |
| ret_valid | input | 3 | Per-slot instruction retiring |
| ret_pidx | input | 18 | Per-slot guard index, 6 bits per slot |
| guard_val | output | 3 | Per-slot value of the named flag |
| commit_en | output | 3 | Per-slot architectural write enable |

## Verification
The bench sweeps all ten tests with operand pairs whose signed and unsigned orderings disagree. A design that mixes up signedness fails on pairs such as all-ones against one, and a design that swaps operands fails on the strict orderings. Compares that target flag 0, or that name the same index twice, catch a design that lets flag 0 drop or lets the true-side write win. Requests with an unused opcode, or with `cmp_valid` low, catch a design that writes from an illegal selector. A read in the same cycle as the compare catches a design that forwards the new value a stage early.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int unsigned CMP_OP_W      = 4;
    localparam int unsigned CMP_NUM_TESTS = 10;

    typedef enum logic [CMP_OP_W-1:0] {
        CMP_EQ  = 4'd0,
        CMP_NE  = 4'd1,
        CMP_LT  = 4'd2,
        CMP_LE  = 4'd3,
        CMP_GT  = 4'd4,
        CMP_GE  = 4'd5,
        CMP_LTU = 4'd6,
        CMP_LEU = 4'd7,
        CMP_GTU = 4'd8,
        CMP_GEU = 4'd9
    } cmp_op_e;

endpackage

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
    import pred_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [CMP_OP_W-1:0] op,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    output logic                outcome,
    output logic                op_legal
);

    logic eq_w, slt_w, ult_w;

    always_comb begin
        eq_w  = (opnd_a == opnd_b);
        slt_w = ($signed(opnd_a) < $signed(opnd_b));
        ult_w = (opnd_a < opnd_b);
    end

    always_comb begin
        outcome  = 1'b0;
        op_legal = 1'b1;
        case (cmp_op_e'(op))
            CMP_EQ:  outcome = eq_w;
            CMP_NE:  outcome = !eq_w;
            CMP_LT:  outcome = slt_w;
            CMP_LE:  outcome = slt_w | eq_w;
            CMP_GT:  outcome = !(slt_w | eq_w);
            CMP_GE:  outcome = !slt_w;
            CMP_LTU: outcome = ult_w;
            CMP_LEU: outcome = ult_w | eq_w;
            CMP_GTU: outcome = !(ult_w | eq_w);
            CMP_GEU: outcome = !ult_w;
            default: op_legal = 1'b0;
        endcase
    end

    // R4
    always_comb begin
        if (op == 4'(CMP_GE) && opnd_a == opnd_b)
            ge_equal_chk: assert (outcome);
    end

endmodule

// File: rtl/pred_flag_file.sv
module pred_flag_file #(
    parameter int unsigned NPRED = 64,
    parameter int unsigned NSLOT = 3,
    localparam int unsigned PW   = $clog2(NPRED)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PW-1:0]       wr_t_idx,
    input  logic [PW-1:0]       wr_f_idx,
    input  logic                wr_val,
    input  logic [NSLOT*PW-1:0] rd_idx,
    output logic [NSLOT-1:0]    rd_val
);

    typedef struct packed {
        logic [NPRED-1:0] flags;
    } file_state_t;

    localparam logic [NPRED-1:0] RESET_FLAGS = NPRED'(1);

    file_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_t_idx != '0) st_d.flags[wr_t_idx] = wr_val;
            if (wr_f_idx != '0) st_d.flags[wr_f_idx] = !wr_val;
        end
        st_d.flags[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.flags <= RESET_FLAGS;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_rd
        assign rd_val[g] = st_q.flags[rd_idx[g*PW +: PW]];
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.flags == RESET_FLAGS));

    // R2
    flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flags[0]);

    // R3
    true_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_t_idx != '0 && wr_t_idx != wr_f_idx)
        |=> (st_q.flags[$past(wr_t_idx)] == $past(wr_val)));

    // R7
    false_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_f_idx != '0)
        |=> (st_q.flags[$past(wr_f_idx)] == !$past(wr_val)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.flags));

endmodule

// File: rtl/pred_retire_gate.sv
module pred_retire_gate #(
    parameter int unsigned NSLOT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] ret_valid,
    input  logic [NSLOT-1:0] guard,
    output logic [NSLOT-1:0] commit_en
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign commit_en[g] = ret_valid[g] & guard[g];

        // R9
        no_idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ret_valid[g] |-> !commit_en[g]);
    end

endmodule

// File: rtl/pred_regfile_top.sv
module pred_regfile_top
    import pred_pkg::*;
#(
    parameter int unsigned NPRED  = 64,
    parameter int unsigned NSLOT  = 3,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned PW    = $clog2(NPRED)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_valid,
    input  logic [CMP_OP_W-1:0] cmp_op,
    input  logic [DATA_W-1:0]   cmp_a,
    input  logic [DATA_W-1:0]   cmp_b,
    input  logic [PW-1:0]       cmp_dst_t,
    input  logic [PW-1:0]       cmp_dst_f,
    input  logic [NSLOT-1:0]    ret_valid,
    input  logic [NSLOT*PW-1:0] ret_pidx,
    output logic [NSLOT-1:0]    guard_val,
    output logic [NSLOT-1:0]    commit_en
);

    logic cmp_res, cmp_legal, wr_en;

    pred_cmp_unit #(.DATA_W(DATA_W)) u_cmp (
        .op       (cmp_op),
        .opnd_a   (cmp_a),
        .opnd_b   (cmp_b),
        .outcome  (cmp_res),
        .op_legal (cmp_legal)
    );

    assign wr_en = cmp_valid & cmp_legal;

    pred_flag_file #(.NPRED(NPRED), .NSLOT(NSLOT)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_t_idx (cmp_dst_t),
        .wr_f_idx (cmp_dst_f),
        .wr_val   (cmp_res),
        .rd_idx   (ret_pidx),
        .rd_val   (guard_val)
    );

    pred_retire_gate #(.NSLOT(NSLOT)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ret_valid (ret_valid),
        .guard     (guard_val),
        .commit_en (commit_en)
    );

    // R8
    illegal_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_op >= 4'(CMP_NUM_TESTS)) |-> !wr_en);

endmodule

// File: tb/sim_pred_regfile_top.sv
module sim_pred_regfile_top;

    localparam int CLK_P = 10;
    localparam int NS    = 3;
    localparam int PW    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_valid = 1'b0;
    logic [3:0]        cmp_op = '0;
    logic [63:0]       cmp_a = '0, cmp_b = '0;
    logic [PW-1:0]     cmp_dst_t = '0, cmp_dst_f = '0;
    logic [NS-1:0]     ret_valid = '0;
    logic [NS*PW-1:0]  ret_pidx = '0;
    logic [NS-1:0]     guard_val, commit_en;

    always #(CLK_P/2) clk = ~clk;

    pred_regfile_top u0 (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
        .ret_valid(ret_valid), .ret_pidx(ret_pidx),
        .guard_val(guard_val), .commit_en(commit_en)
    );

    typedef struct {
        int    slot;
        bit    exp_g;
        bit    exp_c;
        string tag;
    } item_t;

    item_t exp_q[$];
    bit    model[64];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;

    function automatic bit ref_cmp(input int op, input logic [63:0] a, input logic [63:0] b);
        case (op)
            0: return a == b;
            1: return a != b;
            2: return $signed(a) <  $signed(b);
            3: return $signed(a) <= $signed(b);
            4: return $signed(a) >  $signed(b);
            5: return $signed(a) >= $signed(b);
            6: return a <  b;
            7: return a <= b;
            8: return a >  b;
            9: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push_slot(input int s, input int idx, input bit v, input string tag);
        item_t it;
        ret_pidx[s*PW +: PW] = PW'(idx);
        ret_valid[s] = v;
        it.slot  = s;
        it.exp_g = model[idx];
        it.exp_c = v & model[idx];
        it.tag   = tag;
        exp_q.push_back(it);
    endtask

    task automatic read3(input int i0, input int i1, input int i2,
                         input bit [2:0] v, input string tag);
        @(negedge clk);
        cmp_valid = 1'b0;
        push_slot(0, i0, v[0], tag);
        push_slot(1, i1, v[1], tag);
        push_slot(2, i2, v[2], tag);
    endtask

    task automatic issue_cmp(input bit vld, input int op, input logic [63:0] a,
                             input logic [63:0] b, input int t, input int f,
                             input string tag);
        @(negedge clk);
        cmp_valid = vld;
        cmp_op    = 4'(op);
        cmp_a     = a;
        cmp_b     = b;
        cmp_dst_t = PW'(t);
        cmp_dst_f = PW'(f);
        ret_valid = '0;
        // R3: same-cycle read still sees the old value
        push_slot(0, t, 1'b1, "R3 same-cycle");
        push_slot(1, f, 1'b1, "R3 same-cycle");
        if (vld && op < 10) begin
            bit r;
            r = ref_cmp(op, a, b);
            if (t != 0) model[t] = r;
            if (f != 0) model[f] = !r;
        end
        read3(t, f, 0, 3'b111, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                n_checks++;
                if (guard_val[it.slot] !== it.exp_g || commit_en[it.slot] !== it.exp_c) begin
                    n_errors++;
                    $display("FAIL %s slot%0d: guard/commit actual=%b/%b expected=%b/%b",
                             it.tag, it.slot, guard_val[it.slot], commit_en[it.slot],
                             it.exp_g, it.exp_c);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] pa[4];
        logic [63:0] pb[4];
        pa[0] = 64'hFFFF_FFFF_FFFF_FFFF; pb[0] = 64'd1;
        pa[1] = 64'd5;                   pb[1] = 64'd5;
        pa[2] = 64'h8000_0000_0000_0000; pb[2] = 64'h7FFF_FFFF_FFFF_FFFF;
        pa[3] = 64'd3;                   pb[3] = 64'd9;
        for (int i = 0; i < 64; i++) model[i] = (i == 0);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read3(0, 1, 63, 3'b111, "R1 reset");
        read3(17, 42, 5, 3'b111, "R1 reset");
        // R9 invalid slot never commits
        read3(0, 0, 1, 3'b000, "R9 idle");

        // R6 equality / inequality
        issue_cmp(1, 0, 64'd7, 64'd7, 1, 2, "R6 eq");
        issue_cmp(1, 1, 64'd7, 64'd7, 3, 4, "R6 ne");
        // R4 / R5 signed against unsigned
        issue_cmp(1, 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5, 6, "R4 lt");
        issue_cmp(1, 6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 7, 8, "R5 ltu");

        // R2 flag 0 as destination
        issue_cmp(1, 0, 64'd1, 64'd2, 0, 9, "R2 t=0");
        issue_cmp(1, 0, 64'd1, 64'd1, 10, 0, "R2 f=0");
        read3(0, 0, 0, 3'b111, "R2 zero");

        // R7 same destination: inverse wins
        issue_cmp(1, 0, 64'd4, 64'd4, 11, 11, "R7 same dst");
        issue_cmp(1, 1, 64'd4, 64'd4, 12, 12, "R7 same dst");

        // R8 illegal opcodes and invalid requests
        for (int op = 10; op < 16; op++)
            issue_cmp(1, op, 64'd1, 64'd1, 13, 14, "R8 illegal op");
        issue_cmp(0, 0, 64'd1, 64'd1, 15, 16, "R8 no valid");

        // R4 R5 R6 sweep over all tests
        for (int op = 0; op < 10; op++)
            for (int p = 0; p < 4; p++)
                issue_cmp(1, op, pa[p], pb[p], 20 + p, 40 + op, "R4/R5/R6 sweep");

        // R10 earlier flags held
        read3(1, 2, 5, 3'b111, "R10 hold");
        read3(7, 8, 9, 3'b111, "R10 hold");
        // R11 same index on all slots, mixed valids
        read3(10, 10, 10, 3'b101, "R11 shared");
        read3(11, 1, 63, 3'b110, "R11 mixed");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule